// File: doc/BRIEF.md
# Address-Holding One-of-Eight Decoder

This block turns a 3-bit select address into a one-of-eight output vector. The address goes through a hold stage before it reaches the decoder. While the hold control is low, the address goes straight through. In that state the outputs follow the select inputs in the same cycle, like a plain decoder. While hold is high, the block decodes the address it captured at the last clock edge with hold low. Any movement on the select inputs during that time is ignored.

Two gating inputs of opposite polarity qualify every output: one is active high and one is active low. They act combinationally and are never held. This lets several decoders be cascaded into a wider address space. It also lets the block work as a 1-to-8 demultiplexer: keep one gate active and drive the other with a data bit. A parameter selects whether the chosen output is marked by a high level or a low level.

Top module: `addr_hold_decoder8`

## Requirements
- R1: Output bit i corresponds to address value i, where `sel[0]` is the least significant address bit and `sel[2]` the most significant.
- R2: While `hold` is low, the decoded address is the current `sel` value, and the outputs reflect it combinationally in the same cycle.
- R3: While `en_hi` is 1 and `en_lo_n` is 0, exactly one output is at the selected level and the other seven are at the deselected level.
- R4: While `en_hi` is 0 or `en_lo_n` is 1, all eight outputs are at the deselected level.
- R5: While `hold` is high, the decoded address is the `sel` value sampled at the last rising clock edge where `hold` was low, and changes on `sel` have no effect on the outputs.
- R6: The gating inputs act combinationally whatever the state of `hold`. Gating the outputs off and on again during a hold does not change the held address.
- R7: With `en_lo_n` at 0, the addressed output carries `en_hi` as data (selected level for 1, deselected for 0), and every other output stays deselected.
- R8: With `ACTIVE_HIGH`=1 the selected level is 1 and the deselected level is 0. With `ACTIVE_HIGH`=0 the selected level is 0 and the deselected level is 1.
- R9: An asynchronous reset (`rst_n` low) clears the held address to 0, so with `hold` high after reset, output 0 is the one selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address hold register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Select address, bit 0 least significant |
| hold | input | 1 | High freezes the captured address; low passes `sel` through |
| en_hi | input | 1 | Active-high output gate (data input in demux use) |
| en_lo_n | input | 1 | Active-low output gate |
| dout | output | 8 | Decoded outputs, polarity set by `ACTIVE_HIGH` |

## Verification
The gating and the transparent path are combinational, so their results are due in the same cycle: the bench changes inputs away from the clock edge and samples one time unit later. The held address depends on a register. The bench therefore changes `sel` and `hold` only between edges, lets at least one rising edge pass with `hold` low to capture a value, and raises `hold` before the next edge. It then moves `sel` across several edges and checks that the outputs still show the captured value. Both polarities run side by side on the same stimulus, so each check compares one output vector against its complement.

// File: rtl/addr_hold_decoder8.sv
module addr_hold_decoder8 #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       hold,
  input  logic       en_hi,
  input  logic       en_lo_n,
  output logic [7:0] dout
);

  logic [2:0] held_q;
  logic [2:0] addr_eff;
  logic       gate_on;
  logic [7:0] hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= 3'd0;
    else if (!hold) held_q <= sel;
  end

  assign addr_eff = hold ? held_q : sel;
  assign gate_on  = en_hi & ~en_lo_n;
  assign hot      = gate_on ? (8'd1 << addr_eff) : 8'd0;

  generate
    if (ACTIVE_HIGH) begin : g_pos
      assign dout = hot;
    end else begin : g_neg
      assign dout = ~hot;
    end
  endgenerate

endmodule

// File: rtl/addr_hold_decoder8_chk.sv
module addr_hold_decoder8_chk #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel,
  input logic       hold,
  input logic       en_hi,
  input logic       en_lo_n,
  input logic [7:0] dout
);

  logic [7:0] act;
  logic       live;
  assign act  = ACTIVE_HIGH ? dout : ~dout;
  assign live = en_hi && !en_lo_n;

  a_r3_one_selected: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> $countones(act) == 1);

  a_r4_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> act == 8'd0);

  a_r2_follows_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !hold) |-> act[sel]);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold) && live && $past(live)) |-> $stable(act));

endmodule

bind addr_hold_decoder8 addr_hold_decoder8_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .hold(hold),
  .en_hi(en_hi), .en_lo_n(en_lo_n), .dout(dout)
);

// File: tb/sim_addr_hold_decoder8.sv
`timescale 1ns/1ps
module sim_addr_hold_decoder8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       hold = 1'b0;
  logic       en_hi = 1'b0;
  logic       en_lo_n = 1'b1;
  logic [7:0] dout_pos, dout_neg;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  addr_hold_decoder8 #(.ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .hold(hold),
    .en_hi(en_hi), .en_lo_n(en_lo_n), .dout(dout_pos));
  addr_hold_decoder8 #(.ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .hold(hold),
    .en_hi(en_hi), .en_lo_n(en_lo_n), .dout(dout_neg));

  // {sel, en_hi, en_lo_n, expected selected-level pattern}
  localparam logic [12:0] VEC [13] = '{
    {3'd0, 1'b1, 1'b0, 8'b0000_0001},
    {3'd1, 1'b1, 1'b0, 8'b0000_0010},
    {3'd2, 1'b1, 1'b0, 8'b0000_0100},
    {3'd3, 1'b1, 1'b0, 8'b0000_1000},
    {3'd4, 1'b1, 1'b0, 8'b0001_0000},
    {3'd5, 1'b1, 1'b0, 8'b0010_0000},
    {3'd6, 1'b1, 1'b0, 8'b0100_0000},
    {3'd7, 1'b1, 1'b0, 8'b1000_0000},
    {3'd3, 1'b0, 1'b0, 8'b0000_0000},
    {3'd3, 1'b1, 1'b1, 8'b0000_0000},
    {3'd3, 1'b0, 1'b1, 8'b0000_0000},
    {3'd6, 1'b0, 1'b0, 8'b0000_0000},
    {3'd6, 1'b1, 1'b0, 8'b0100_0000}
  };

  task automatic check(input string tag, input logic [7:0] exp);
    #1;
    checks++;
    if (dout_pos !== exp) begin
      errors++;
      $display("FAIL %s active-high: got %b expected %b", tag, dout_pos, exp);
    end
    checks++;
    if (dout_neg !== ~exp) begin
      errors++;
      $display("FAIL %s active-low: got %b expected %b", tag, dout_neg, ~exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset clears held address; hold high selects output 0
    hold = 1'b1; sel = 3'd3; en_hi = 1'b1; en_lo_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 in reset", 8'b0000_0001);
    rst_n = 1'b1;
    sel = 3'd6;
    repeat (2) @(negedge clk);
    check("R9 after reset", 8'b0000_0001);

    // Vector walk, transparent path: R1 R2 R3 R4 R7 R8
    hold = 1'b0;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      {sel, en_hi, en_lo_n} = VEC[i][12:8];
      check($sformatf("R1/R2/R3/R4/R7/R8 vec %0d", i), VEC[i][7:0]);
    end

    // R5: capture 5, then move sel during hold
    @(negedge clk);
    en_hi = 1'b1; en_lo_n = 1'b0; sel = 3'd5; hold = 1'b0;
    @(negedge clk);
    hold = 1'b1; sel = 3'd2;
    check("R5 held", 8'b0010_0000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      sel = 3'(k + 1);
      check("R5 sel ignored", 8'b0010_0000);
    end

    // R6: gates act during hold and do not disturb held address
    @(negedge clk);
    en_lo_n = 1'b1;
    check("R6 gate off in hold", 8'b0000_0000);
    @(negedge clk);
    en_lo_n = 1'b0; en_hi = 1'b0;
    check("R6 en_hi off in hold", 8'b0000_0000);
    @(negedge clk);
    en_hi = 1'b1;
    check("R6 regated keeps held", 8'b0010_0000);

    // R7: demux with held address
    @(negedge clk);
    en_hi = 1'b0;
    check("R7 demux data 0", 8'b0000_0000);
    @(negedge clk);
    en_hi = 1'b1;
    check("R7 demux data 1", 8'b0010_0000);

    // R2: release hold, follows sel at once
    @(negedge clk);
    sel = 3'd7; hold = 1'b0;
    check("R2 release", 8'b1000_0000);
    @(negedge clk);
    sel = 3'd0;
    check("R2 follow", 8'b0000_0001);

    // R9: async reset mid-run clears captured address
    @(negedge clk);
    sel = 3'd4;
    @(negedge clk);
    hold = 1'b1;
    check("R5 recapture", 8'b0001_0000);
    rst_n = 1'b0;
    check("R9 async clear", 8'b0000_0001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 held zero", 8'b0000_0001);

    finish_run();
  end
endmodule